// File: doc/BRIEF.md
# Bus Transaction Performance Monitor

This block sits beside a memory-mapped bus and watches two valid/ready channels: one carrying requests and one carrying responses. It never drives either channel. While it is running it accumulates the raw counts needed to judge how well the bus is used. These are the cycles in the window, the cycles in which anything moved, the handshakes on each channel, the bytes moved, and the per-cycle number of requests still waiting for a response. From these counts software can work out efficiency, bandwidth and average queue depth.

Each accepted request is stamped with a free-running cycle stamp in a small in-order stamp queue. When the next response handshake arrives, the difference gives the request-to-response latency. The monitor keeps the largest and smallest latency seen. Any latency above a programmable bound raises a sticky alarm and is counted. Start, stop and clear pulses control the window. All results are read through a one-cycle registered read port.

Top module: `perfmon_top`

## Requirements
- R1: A start pulse sets `running` at the next edge and a stop pulse clears it; stop wins if both are high. The total-cycle register (address 0) grows by one for each cycle in which `running` is high, so the cycle carrying the stop pulse still counts. While stopped and not cleared, no statistic changes. Status (address 10) reads bit 0 = running, bit 1 = alarm.
- R2: The busy-cycle register (address 1) grows by one for every running cycle with a handshake (valid and ready both high) on either channel. Under continuous back-to-back traffic it equals the total-cycle register.
- R3: Request handshakes (address 2) and response handshakes (address 3) are counted separately, one per cycle, including on consecutive cycles.
- R4: The byte register (address 4) adds DATA_BYTES for every handshake in a running cycle, so a cycle with handshakes on both channels adds twice DATA_BYTES.
- R5: Each running cycle adds the current outstanding count (accepted requests minus responses, tracked even while stopped) to a SUM_W-bit sum (address 5). The largest such count is held at address 6.
- R6: Latency is the number of cycles from a request handshake to the response handshake that retires it, in request order. On responses in running cycles the largest value is kept at address 7 and the smallest at address 8. Address 8 reads all-ones in LAT_W bits when nothing has been recorded.
- R7: A recorded latency strictly greater than `lat_bound` increments the violation count (address 9) and sets `lat_alarm`, which stays high until a clear.
- R8: Every counter and sum saturates at its all-ones value instead of wrapping.
- R9: A clear pulse zeroes every statistic and the alarm at the next edge and overrides any update in the same cycle. It resets the minimum latency to all-ones. It leaves `running` and outstanding tracking unchanged.
- R10: With `rd_en` high, `rd_data` shows the register at `rd_addr` one edge later, zero-extended, as its value before that edge. Addresses 11 to 15 read zero. Without `rd_en`, `rd_data` holds its value.
- R11: After reset the monitor is stopped, the alarm is low, `rd_data` is zero and all statistics are zero, with the minimum latency at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request channel valid (observed) |
| req_ready | input | 1 | Request channel ready (observed) |
| rsp_valid | input | 1 | Response channel valid (observed) |
| rsp_ready | input | 1 | Response channel ready (observed) |
| ctl_start | input | 1 | Start pulse |
| ctl_stop | input | 1 | Stop pulse |
| ctl_clear | input | 1 | Clear pulse |
| lat_bound | input | LAT_W | Highest latency not flagged |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Register address |
| rd_data | output | SUM_W | Registered read data |
| running | output | 1 | Measurement window open |
| lat_alarm | output | 1 | Sticky latency violation |

## Verification
Control pulses and bus handshakes sampled at an edge change `running`, `lat_alarm` and every statistic at that same edge. A read issued with `rd_en` at an edge returns the value from before that edge's update, one edge later. The bench model applies stimulus at that edge and compares the three outputs at the following falling edge. It keeps a separate copy of each register's pre-edge value for the read path, so each comparison lands in the cycle where the result is due. Directed reads add checks at the same one-edge offset for streaming efficiency, saturation, clear and the reset state.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    PM_TOTAL   = 4'd0,
    PM_BUSY    = 4'd1,
    PM_REQS    = 4'd2,
    PM_RSPS    = 4'd3,
    PM_BYTES   = 4'd4,
    PM_OUTSUM  = 4'd5,
    PM_OUTMAX  = 4'd6,
    PM_LATMAX  = 4'd7,
    PM_LATMIN  = 4'd8,
    PM_VIOL    = 4'd9,
    PM_STATUS  = 4'd10
  } pm_reg_e;

  // index of each single-step event counter
  localparam int EV_TOTAL = 0;
  localparam int EV_BUSY  = 1;
  localparam int EV_REQS  = 2;
  localparam int EV_RSPS  = 3;
  localparam int EV_VIOL  = 4;
  localparam int EV_NUM   = 5;
endpackage

// File: rtl/perfmon_satcnt.sv
module perfmon_satcnt #(
  parameter int W     = 32,
  parameter int INC_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [INC_W-1:0] inc,
  output logic [W-1:0]     q
);
  logic [W:0]   sum;
  logic [W-1:0] q_n;

  always_comb begin
    sum = {1'b0, q} + (W+1)'(inc);
    q_n = q;
    if (clr) begin
      q_n = '0;
    end else if (en) begin
      q_n = sum[W] ? '1 : sum[W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/perfmon_maxtrk.sv
module perfmon_maxtrk #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] val,
  output logic [W-1:0] q
);
  logic [W-1:0] q_n;

  always_comb begin
    q_n = q;
    if (clr)                  q_n = '0;
    else if (en && (val > q)) q_n = val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_n;
  end
endmodule

// File: rtl/perfmon_tsfifo.sv
module perfmon_tsfifo #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_n, rd_n;
  logic [CW-1:0] count_n;

  always_comb begin
    wr_n    = push ? wr_q + AW'(1) : wr_q;
    rd_n    = pop  ? rd_q + AW'(1) : rd_q;
    count_n = count + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      count <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      count <= count_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  assign head = mem[rd_q];
endmodule

// File: rtl/perfmon_latstat.sv
module perfmon_latstat #(
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sample,
  input  logic [LAT_W-1:0] lat,
  input  logic [LAT_W-1:0] bound,
  output logic [LAT_W-1:0] lat_max,
  output logic [LAT_W-1:0] lat_min,
  output logic             over
);
  logic [LAT_W-1:0] max_n, min_n;

  always_comb begin
    over  = sample && (lat > bound);
    max_n = lat_max;
    min_n = lat_min;
    if (clr) begin
      max_n = '0;
      min_n = '1;
    end else if (sample) begin
      if (lat > lat_max) max_n = lat;
      if (lat < lat_min) min_n = lat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_max <= '0;
      lat_min <= '1;
    end else begin
      lat_max <= max_n;
      lat_min <= min_n;
    end
  end
endmodule

// File: rtl/perfmon_top.sv
module perfmon_top #(
  parameter int DATA_BYTES = 4,
  parameter int CNT_W      = 32,
  parameter int SUM_W      = 48,
  parameter int LAT_W      = 16,
  parameter int DEPTH      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic             rsp_ready,
  input  logic             ctl_start,
  input  logic             ctl_stop,
  input  logic             ctl_clear,
  input  logic [LAT_W-1:0] lat_bound,
  input  logic             rd_en,
  input  logic [3:0]       rd_addr,
  output logic [SUM_W-1:0] rd_data,
  output logic             running,
  output logic             lat_alarm
);
  import perfmon_pkg::*;

  localparam int AW    = $clog2(DEPTH);
  localparam int OCC_W = AW + 1;
  localparam int BI_W  = $clog2(2*DATA_BYTES + 1);

  logic             req_fire, rsp_fire, have_entry, retire, sample, over;
  logic [LAT_W-1:0] stamp_q, stamp_n, head, lat;
  logic [OCC_W-1:0] occ;
  logic [1:0]       nfire;
  logic [BI_W-1:0]  byte_inc;
  logic             run_n, alarm_n;
  logic [EV_NUM-1:0] ev_inc;
  logic [CNT_W-1:0] ev_cnt [EV_NUM];
  logic [CNT_W-1:0] total_cnt, busy_cnt, out_max;
  logic [SUM_W-1:0] byte_cnt, out_sum;
  logic [LAT_W-1:0] lat_max, lat_min;
  logic [SUM_W-1:0] rd_mux, rd_n;

  // handshake decode
  always_comb begin
    req_fire   = req_valid && req_ready;
    rsp_fire   = rsp_valid && rsp_ready;
    have_entry = (occ != '0);
    retire     = rsp_fire && have_entry;
    sample     = retire && running;
    nfire      = {1'b0, req_fire} + {1'b0, rsp_fire};
    byte_inc   = BI_W'(nfire) * BI_W'(DATA_BYTES);
    stamp_n    = stamp_q + LAT_W'(1);
    lat        = stamp_q - head;
  end

  // window control and sticky alarm
  always_comb begin
    run_n = running;
    if (ctl_stop)       run_n = 1'b0;
    else if (ctl_start) run_n = 1'b1;
    alarm_n = lat_alarm;
    if (ctl_clear)      alarm_n = 1'b0;
    else if (over)      alarm_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q   <= '0;
      running   <= 1'b0;
      lat_alarm <= 1'b0;
    end else begin
      stamp_q   <= stamp_n;
      running   <= run_n;
      lat_alarm <= alarm_n;
    end
  end

  // in-order stamp queue: tracked regardless of the window
  perfmon_tsfifo #(.DEPTH(DEPTH), .W(LAT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(req_fire), .pop(retire),
    .din(stamp_q), .head(head), .count(occ)
  );

  perfmon_latstat #(.LAT_W(LAT_W)) u_lat (
    .clk(clk), .rst_n(rst_n), .clr(ctl_clear), .sample(sample),
    .lat(lat), .bound(lat_bound), .lat_max(lat_max), .lat_min(lat_min),
    .over(over)
  );

  // single-step event counters
  always_comb begin
    ev_inc           = '0;
    ev_inc[EV_TOTAL] = 1'b1;
    ev_inc[EV_BUSY]  = req_fire || rsp_fire;
    ev_inc[EV_REQS]  = req_fire;
    ev_inc[EV_RSPS]  = rsp_fire;
    ev_inc[EV_VIOL]  = over;
  end

  for (genvar g = 0; g < EV_NUM; g++) begin : g_ev
    perfmon_satcnt #(.W(CNT_W), .INC_W(1)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(ctl_clear), .en(running),
      .inc(ev_inc[g]), .q(ev_cnt[g])
    );
  end

  assign total_cnt = ev_cnt[EV_TOTAL];
  assign busy_cnt  = ev_cnt[EV_BUSY];

  perfmon_satcnt #(.W(SUM_W), .INC_W(BI_W)) u_bytes (
    .clk(clk), .rst_n(rst_n), .clr(ctl_clear), .en(running),
    .inc(byte_inc), .q(byte_cnt)
  );

  perfmon_satcnt #(.W(SUM_W), .INC_W(OCC_W)) u_outsum (
    .clk(clk), .rst_n(rst_n), .clr(ctl_clear), .en(running),
    .inc(occ), .q(out_sum)
  );

  perfmon_maxtrk #(.W(CNT_W)) u_outmax (
    .clk(clk), .rst_n(rst_n), .clr(ctl_clear), .en(running),
    .val(CNT_W'(occ)), .q(out_max)
  );

  // register read port
  always_comb begin
    case (pm_reg_e'(rd_addr))
      PM_TOTAL:  rd_mux = SUM_W'(ev_cnt[EV_TOTAL]);
      PM_BUSY:   rd_mux = SUM_W'(ev_cnt[EV_BUSY]);
      PM_REQS:   rd_mux = SUM_W'(ev_cnt[EV_REQS]);
      PM_RSPS:   rd_mux = SUM_W'(ev_cnt[EV_RSPS]);
      PM_BYTES:  rd_mux = byte_cnt;
      PM_OUTSUM: rd_mux = out_sum;
      PM_OUTMAX: rd_mux = SUM_W'(out_max);
      PM_LATMAX: rd_mux = SUM_W'(lat_max);
      PM_LATMIN: rd_mux = SUM_W'(lat_min);
      PM_VIOL:   rd_mux = SUM_W'(ev_cnt[EV_VIOL]);
      PM_STATUS: rd_mux = SUM_W'({lat_alarm, running});
      default:   rd_mux = '0;
    endcase
    rd_n = rd_en ? rd_mux : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_n;
  end
endmodule

// File: rtl/perfmon_chk.sv
module perfmon_chk #(
  parameter int CNT_W = 32,
  parameter int OCC_W = 4,
  parameter int DEPTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_start,
  input logic             ctl_stop,
  input logic             ctl_clear,
  input logic             running,
  input logic             lat_alarm,
  input logic [CNT_W-1:0] total,
  input logic [CNT_W-1:0] busy,
  input logic [OCC_W-1:0] occ
);
  // R1
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stop |=> !running);
  // R1
  start_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_start && !ctl_stop) |=> running);
  // R1
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !ctl_clear) |=> $stable(total));
  // R2
  busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy <= total);
  // R9
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clear |=> (total == '0 && busy == '0));
  // R7
  alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat_alarm) |-> $past(ctl_clear));
  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(DEPTH));
endmodule

bind perfmon_top perfmon_chk #(.CNT_W(CNT_W), .OCC_W(OCC_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_start(ctl_start), .ctl_stop(ctl_stop),
  .ctl_clear(ctl_clear), .running(running), .lat_alarm(lat_alarm),
  .total(total_cnt), .busy(busy_cnt), .occ(occ)
);

// File: tb/perfmon_top_test.sv
module perfmon_top_test;
  localparam int DB    = 4;
  localparam int CNT_W = 10;
  localparam int SUM_W = 14;
  localparam int LAT_W = 8;
  localparam int DEPTH = 8;
  localparam longint CMAX = (64'd1 << CNT_W) - 1;
  localparam longint SMAX = (64'd1 << SUM_W) - 1;
  localparam longint LMAX = (64'd1 << LAT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready = 0, rsp_valid = 0, rsp_ready = 0;
  logic ctl_start = 0, ctl_stop = 0, ctl_clear = 0;
  logic [LAT_W-1:0] lat_bound = '1;
  logic rd_en = 0;
  logic [3:0] rd_addr = '0;
  logic [SUM_W-1:0] rd_data;
  logic running, lat_alarm;

  int tests = 0, fails = 0;
  int mode = 0;            // 0 idle, 1 random, 2 stream, 3 drain
  bit use_f = 0;
  logic [3:0] fa = '0;
  bit chk_on = 0;

  always #5 clk = ~clk;

  perfmon_top #(.DATA_BYTES(DB), .CNT_W(CNT_W), .SUM_W(SUM_W), .LAT_W(LAT_W),
                .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .ctl_start(ctl_start),
    .ctl_stop(ctl_stop), .ctl_clear(ctl_clear), .lat_bound(lat_bound),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .running(running),
    .lat_alarm(lat_alarm)
  );

  // ---------------- behavioural reference model ----------------
  longint m_total, m_busy, m_reqs, m_rsps, m_bytes, m_osum, m_omax;
  longint m_lmax, m_lmin, m_viol, m_rd, cyc;
  bit m_run, m_alarm;
  longint q_ts[$];

  function automatic longint satadd(longint a, longint b, longint lim);
    return (a + b > lim) ? lim : a + b;
  endfunction

  function automatic longint mread(logic [3:0] a);
    case (a)
      4'd0:  return m_total;
      4'd1:  return m_busy;
      4'd2:  return m_reqs;
      4'd3:  return m_rsps;
      4'd4:  return m_bytes;
      4'd5:  return m_osum;
      4'd6:  return m_omax;
      4'd7:  return m_lmax;
      4'd8:  return m_lmin;
      4'd9:  return m_viol;
      4'd10: return {62'd0, m_alarm, m_run};
      default: return 0;
    endcase
  endfunction

  function automatic string rtag(logic [3:0] a);
    case (a)
      4'd0, 4'd10: return "R1";
      4'd1:        return "R2";
      4'd2, 4'd3:  return "R3";
      4'd4:        return "R4";
      4'd5, 4'd6:  return "R5";
      4'd7, 4'd8:  return "R6";
      4'd9:        return "R7";
      default:     return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_total = 0; m_busy = 0; m_reqs = 0; m_rsps = 0; m_bytes = 0;
      m_osum = 0; m_omax = 0; m_lmax = 0; m_lmin = LMAX; m_viol = 0;
      m_rd = 0; m_run = 0; m_alarm = 0; cyc = 0; q_ts.delete();
    end else begin
      bit rq, rs, smp;
      longint lat, occ;
      if (rd_en) m_rd = mread(rd_addr);
      rq  = req_valid && req_ready;
      rs  = rsp_valid && rsp_ready;
      occ = q_ts.size();
      smp = 0; lat = 0;
      if (rs && q_ts.size() > 0) begin
        lat = cyc - q_ts.pop_front();
        smp = m_run;
      end
      if (ctl_clear) begin
        m_total = 0; m_busy = 0; m_reqs = 0; m_rsps = 0; m_bytes = 0;
        m_osum = 0; m_omax = 0; m_lmax = 0; m_lmin = LMAX; m_viol = 0;
        m_alarm = 0;
      end else if (m_run) begin
        m_total = satadd(m_total, 1, CMAX);
        if (rq || rs) m_busy = satadd(m_busy, 1, CMAX);
        if (rq) m_reqs = satadd(m_reqs, 1, CMAX);
        if (rs) m_rsps = satadd(m_rsps, 1, CMAX);
        m_bytes = satadd(m_bytes, DB * (int'(rq) + int'(rs)), SMAX);
        m_osum  = satadd(m_osum, occ, SMAX);
        if (occ > m_omax) m_omax = occ;
        if (smp) begin
          if (lat > m_lmax) m_lmax = lat;
          if (lat < m_lmin) m_lmin = lat;
          if (lat > longint'(lat_bound)) begin
            m_viol  = satadd(m_viol, 1, CMAX);
            m_alarm = 1;
          end
        end
      end
      if (rq) q_ts.push_back(cyc);
      if (ctl_stop)       m_run = 0;
      else if (ctl_start) m_run = 1;
      cyc++;
    end
  end

  // ---------------- stimulus generator ----------------
  always @(negedge clk) begin
    int out;
    out = q_ts.size();
    req_valid = 0; req_ready = 0; rsp_valid = 0; rsp_ready = 0;
    case (mode)
      1: begin
        req_valid = ($urandom % 3) != 0;
        req_ready = (out < DEPTH) && ($urandom % 2 == 1);
        rsp_valid = (out > 0) && ($urandom % 2 == 1);
        rsp_ready = ($urandom % 4) != 0;
      end
      2: begin
        req_valid = out < DEPTH; req_ready = out < DEPTH;
        rsp_valid = out > 0;     rsp_ready = out > 0;
      end
      3: begin
        rsp_valid = out > 0; rsp_ready = out > 0;
      end
      default: ;
    endcase
    rd_en = 1'b1;
    rd_addr = use_f ? fa : rd_addr + 4'd1;
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      tests++;
      if (rd_data !== m_rd[SUM_W-1:0]) begin
        fails++;
        $display("FAIL %s read path: rd_data=%0d expected %0d", rtag(rd_addr - 4'd1),
                 rd_data, m_rd[SUM_W-1:0]);
      end
      tests++;
      if (running !== m_run) begin
        fails++;
        $display("FAIL R1 running=%0b expected %0b", running, m_run);
      end
      tests++;
      if (lat_alarm !== m_alarm) begin
        fails++;
        $display("FAIL R7 lat_alarm=%0b expected %0b", lat_alarm, m_alarm);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic check(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mode(int m);
    @(posedge clk); mode = m;
  endtask

  task automatic pulse_start(); @(negedge clk); ctl_start = 1; @(negedge clk); ctl_start = 0; endtask
  task automatic pulse_stop();  @(negedge clk); ctl_stop  = 1; @(negedge clk); ctl_stop  = 0; endtask
  task automatic pulse_clear(); @(negedge clk); ctl_clear = 1; @(negedge clk); ctl_clear = 0; endtask

  task automatic read_reg(logic [3:0] a, output longint v);
    @(posedge clk); fa = a; use_f = 1;
    @(negedge clk);
    @(negedge clk);
    v = rd_data;
    use_f = 0;
  endtask

  task automatic run_cycles(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // ---------------- main sequence ----------------
  initial begin
    longint v, v2;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 rd_data after reset", rd_data, 0);
    check("R11 running after reset", running, 0);
    check("R11 alarm after reset", lat_alarm, 0);
    rst_n = 1'b1;
    read_reg(4'd8, v);
    check("R11 min latency after reset", v, LMAX);
    read_reg(4'd0, v);
    check("R11 total after reset", v, 0);
    chk_on = 1;

    // random traffic, generous bound
    lat_bound = '1;
    set_mode(1);
    pulse_start();
    run_cycles(400);
    pulse_stop();

    // stopped with traffic: statistics frozen (R1)
    read_reg(4'd2, v);
    run_cycles(60);
    read_reg(4'd2, v2);
    check("R1 request count frozen while stopped", v2, v);
    check("R3 requests seen in window", (v > 0) ? 1 : 0, 1);

    // clear while stopped (R9)
    set_mode(0);
    pulse_clear();
    read_reg(4'd2, v);
    check("R9 request count after clear", v, 0);
    read_reg(4'd8, v);
    check("R9 min latency after clear", v, LMAX);
    read_reg(4'd10, v);
    check("R9 status after clear", v, 0);
    read_reg(4'd13, v);
    check("R10 unmapped address", v, 0);

    // tight bound: violations (R7)
    lat_bound = 8'd2;
    set_mode(1);
    pulse_start();
    run_cycles(400);
    pulse_stop();
    check("R7 alarm raised by long latency", lat_alarm, 1);
    read_reg(4'd9, v);
    check("R7 violation count nonzero", (v > 0) ? 1 : 0, 1);
    run_cycles(20);
    check("R7 alarm stays high", lat_alarm, 1);

    // drain, then streaming back-to-back (R2, R3)
    set_mode(3);
    run_cycles(20);
    pulse_clear();
    check("R9 alarm cleared", lat_alarm, 0);
    set_mode(2);
    pulse_start();
    run_cycles(60);
    pulse_stop();
    set_mode(0);
    read_reg(4'd0, v);
    read_reg(4'd1, v2);
    check("R2 busy equals total under streaming", v2, v);
    check("R2 window is nonempty", (v > 50) ? 1 : 0, 1);
    read_reg(4'd6, v);
    check("R5 outstanding maximum while streaming", v, 1);

    // saturation (R8)
    set_mode(3);
    run_cycles(10);
    pulse_clear();
    set_mode(2);
    pulse_start();
    run_cycles(2200);
    read_reg(4'd0, v);
    check("R8 total saturates", v, CMAX);
    read_reg(4'd4, v);
    check("R8 bytes saturate", v, SMAX);
    pulse_stop();
    set_mode(0);
    run_cycles(5);

    finish_run();
  end
endmodule